// File: doc/BRIEF.md
# Shared Resource Semaphore Register Unit

This unit arbitrates shared resources among three agents: a host software agent, an embedded firmware agent, and an internal hardware agent. The host and the firmware each have their own simple register port. The hardware agent takes part only through its flash-busy input.

The unit holds two locks: a driver lock and a register lock. Either lock is taken by reading it. A read that finds the lock free returns a clear bit and takes the lock for the reader in the same operation. The register lock guards the ownership register. That register holds one host bit per resource, one firmware bit per resource except the management resource, and a read-only copy of the flash-busy input. Ownership bits change only through a write from the agent that currently holds the register lock. Retry loops and timeouts belong to the agents.

Each lock is a three-state machine: `LK_FREE`, `LK_HOST` and `LK_FW`. It has four transitions:
- *fw take*: `LK_FREE` to `LK_FW`, on a firmware read of the lock.
- *host take*: `LK_FREE` to `LK_HOST`, on a host read with no firmware read in the same cycle.
- *host free*: `LK_HOST` to `LK_FREE`, on a host write of 0 to the lock bit.
- *fw free*: `LK_FW` to `LK_FREE`, on a firmware write of 0 to the lock bit.

All other inputs hold the state.

Top module: `hwsem_unit`

## Requirements
- R1: The driver lock is bit 0 at address 0. A read that finds it free returns 0 and grants the lock to the reader. A read while the lock is held returns 1.
- R2: The register lock is bit 31 at address 1. It follows the same read-to-take rule as the driver lock.
- R3: Only the holder releases a lock, by writing 0 to the lock bit. A write of 0 from the non-holder has no effect.
- R4: At address 1, the host bit for resource r sits at bit r and the firmware bit at bit r+5. Bit 10 mirrors flash_busy. Read data appears on rdata in the cycle after the read. rd is ignored while wr is high on the same port.
- R5: A write from the lock holder with bit r set claims resource r. The claim succeeds only if the other agent's bit for r is clear. A bit the agent already owns stays set.
- R6: A claim of resource 3 (the non-volatile memory) also requires flash_busy to be low.
- R7: Resource 4 (management) has only a host bit. A firmware write to bit 9 has no effect.
- R8: A write clears or sets only the writing agent's own ownership bits. The other agent's bits are left unchanged.
- R9: A write to address 1 from a port that does not hold the register lock is ignored and sets the sticky sem_err output.
- R10: If both ports read a free lock in the same cycle, the firmware port receives 0 and the lock, and the host port reads 1.
- R11: Reset frees both locks and clears all ownership bits, sem_err and both rdata registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | AW | Host register address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, registered |
| fw_rd | input | 1 | Firmware read strobe |
| fw_wr | input | 1 | Firmware write strobe |
| fw_addr | input | AW | Firmware register address |
| fw_wdata | input | DW | Firmware write data |
| fw_rdata | output | DW | Firmware read data, registered |
| flash_busy | input | 1 | Hardware owns the flash |
| sem_err | output | 1 | Sticky error: ownership write made without the register lock |

## Verification
Lock reads are tried from one port at a time and from both ports in the same cycle. This separates a plain grant from the firmware-wins tie-break, and a holder's re-read from a non-holder's read.

Ownership writes are tried in three cases:
- with the other agent's bit set, which tells a denied claim from a granted one;
- with flash_busy high and then low, which isolates the extra hardware condition on resource 3;
- from the port that lacks the lock, which tells the error path from a silent update.

A firmware write to the management slot and a release write that carries the other agent's bits check that each agent touches only its own bits.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;

    // Lock holder encoding shared by both lock instances.
    typedef enum logic [1:0] {
        LK_FREE = 2'd0,
        LK_HOST = 2'd1,
        LK_FW   = 2'd2
    } lk_state_e;

    // Firmware ownership bit of resource r sits this far above the host bit.
    localparam int FW_SHIFT = 5;

endpackage

// File: rtl/hwsem_lock.sv
module hwsem_lock
    import hwsem_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      host_take,
    input  logic      fw_take,
    input  logic      host_free,
    input  logic      fw_free,
    output lk_state_e state,
    output logic      held,
    output logic      host_rbit,
    output logic      fw_rbit
);

    lk_state_e state_q;
    lk_state_e state_d;

    // Next-state logic; firmware takes precedence on a free lock.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_FREE: begin
                if (fw_take) begin
                    state_d = LK_FW;
                end else if (host_take) begin
                    state_d = LK_HOST;
                end
            end
            LK_HOST: begin
                if (host_free) begin
                    state_d = LK_FREE;
                end
            end
            LK_FW: begin
                if (fw_free) begin
                    state_d = LK_FREE;
                end
            end
            default: state_d = LK_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: the value each reader observes this cycle.
    always_comb begin
        state     = state_q;
        held      = (state_q != LK_FREE);
        fw_rbit   = (state_q != LK_FREE);
        host_rbit = (state_q != LK_FREE) | fw_take;
    end

endmodule

// File: rtl/hwsem_owner.sv
module hwsem_owner #(
    parameter int NRES    = 5,
    parameter int NVM_IDX = 3,
    localparam int NFW    = NRES - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            host_wen,
    input  logic            fw_wen,
    input  logic [NRES-1:0] host_req,
    input  logic [NFW-1:0]  fw_req,
    input  logic            flash_busy,
    output logic [NRES-1:0] host_own,
    output logic [NFW-1:0]  fw_own
);

    for (genvar r = 0; r < NRES; r++) begin : g_res
        logic host_q;
        logic hw_block;
        logic partner;

        assign hw_block    = (r == NVM_IDX) ? flash_busy : 1'b0;
        assign host_own[r] = host_q;

        if (r < NFW) begin : g_pair
            logic fw_q;
            assign partner   = fw_q;
            assign fw_own[r] = fw_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    fw_q <= 1'b0;
                end else if (fw_wen) begin
                    fw_q <= fw_req[r] & (fw_q | (~host_q & ~hw_block));
                end
            end
        end else begin : g_solo
            // Management resource: no firmware partner bit.
            assign partner = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                host_q <= 1'b0;
            end else if (host_wen) begin
                host_q <= host_req[r] & (host_q | (~partner & ~hw_block));
            end
        end
    end

endmodule

// File: rtl/hwsem_rdport.sv
module hwsem_rdport #(
    parameter int DW       = 32,
    parameter int AW       = 2,
    parameter int ADDR_DRV = 0,
    parameter int ADDR_OWN = 1,
    localparam int LOCK_POS = DW - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic          drv_bit,
    input  logic          reg_bit,
    input  logic [DW-1:0] own_img,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mux_d;
    logic [DW-1:0] rdata_q;

    always_comb begin
        mux_d = '0;
        if (addr == AW'(ADDR_DRV)) begin
            mux_d[0] = drv_bit;
        end else if (addr == AW'(ADDR_OWN)) begin
            mux_d           = own_img;
            mux_d[LOCK_POS] = reg_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= mux_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hwsem_unit.sv
module hwsem_unit
    import hwsem_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 2,
    parameter int NRES      = 5,
    parameter int NVM_IDX   = 3,
    parameter int FLASH_POS = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          fw_rd,
    input  logic          fw_wr,
    input  logic [AW-1:0] fw_addr,
    input  logic [DW-1:0] fw_wdata,
    output logic [DW-1:0] fw_rdata,
    input  logic          flash_busy,
    output logic          sem_err
);

    localparam int NFW      = NRES - 1;
    localparam int LOCK_POS = DW - 1;
    localparam int ADDR_DRV = 0;
    localparam int ADDR_OWN = 1;

    // Qualified strobes: a write on a port masks its read.
    logic host_rdq, fw_rdq;
    logic host_at_drv, host_at_own, fw_at_drv, fw_at_own;

    assign host_rdq    = host_rd & ~host_wr;
    assign fw_rdq      = fw_rd & ~fw_wr;
    assign host_at_drv = (host_addr == AW'(ADDR_DRV));
    assign host_at_own = (host_addr == AW'(ADDR_OWN));
    assign fw_at_drv   = (fw_addr == AW'(ADDR_DRV));
    assign fw_at_own   = (fw_addr == AW'(ADDR_OWN));

    // Driver lock
    lk_state_e drv_state;
    logic      drv_held, drv_host_rbit, drv_fw_rbit;

    hwsem_lock u_drv (
        .clk       (clk),
        .rst       (rst),
        .host_take (host_rdq & host_at_drv),
        .fw_take   (fw_rdq & fw_at_drv),
        .host_free (host_wr & host_at_drv & ~host_wdata[0]),
        .fw_free   (fw_wr & fw_at_drv & ~fw_wdata[0]),
        .state     (drv_state),
        .held      (drv_held),
        .host_rbit (drv_host_rbit),
        .fw_rbit   (drv_fw_rbit)
    );

    // Register lock (guards the ownership register)
    lk_state_e reg_state;
    logic      reg_held, reg_host_rbit, reg_fw_rbit;

    hwsem_lock u_reg (
        .clk       (clk),
        .rst       (rst),
        .host_take (host_rdq & host_at_own),
        .fw_take   (fw_rdq & fw_at_own),
        .host_free (host_wr & host_at_own & ~host_wdata[LOCK_POS]),
        .fw_free   (fw_wr & fw_at_own & ~fw_wdata[LOCK_POS]),
        .state     (reg_state),
        .held      (reg_held),
        .host_rbit (reg_host_rbit),
        .fw_rbit   (reg_fw_rbit)
    );

    // Ownership bits
    logic            host_own_wen, fw_own_wen;
    logic [NRES-1:0] host_own;
    logic [NFW-1:0]  fw_own;

    assign host_own_wen = host_wr & host_at_own & (reg_state == LK_HOST);
    assign fw_own_wen   = fw_wr & fw_at_own & (reg_state == LK_FW);

    hwsem_owner #(
        .NRES    (NRES),
        .NVM_IDX (NVM_IDX)
    ) u_own (
        .clk        (clk),
        .rst        (rst),
        .host_wen   (host_own_wen),
        .fw_wen     (fw_own_wen),
        .host_req   (host_wdata[NRES-1:0]),
        .fw_req     (fw_wdata[FW_SHIFT +: NFW]),
        .flash_busy (flash_busy),
        .host_own   (host_own),
        .fw_own     (fw_own)
    );

    // Sticky error for ownership writes without the register lock
    logic err_q, err_hit;

    assign err_hit = (host_wr & host_at_own & (reg_state != LK_HOST))
                   | (fw_wr & fw_at_own & (reg_state != LK_FW));

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (err_hit) begin
            err_q <= 1'b1;
        end
    end

    assign sem_err = err_q;

    // Ownership image seen by readers (lock bit merged in the read port)
    logic [DW-1:0] own_img;

    always_comb begin
        own_img                   = '0;
        own_img[NRES-1:0]         = host_own;
        own_img[FW_SHIFT +: NFW]  = fw_own;
        own_img[FLASH_POS]        = flash_busy;
    end

    hwsem_rdport #(
        .DW       (DW),
        .AW       (AW),
        .ADDR_DRV (ADDR_DRV),
        .ADDR_OWN (ADDR_OWN)
    ) u_host_rd (
        .clk     (clk),
        .rst     (rst),
        .rd      (host_rdq),
        .addr    (host_addr),
        .drv_bit (drv_host_rbit),
        .reg_bit (reg_host_rbit),
        .own_img (own_img),
        .rdata   (host_rdata)
    );

    hwsem_rdport #(
        .DW       (DW),
        .AW       (AW),
        .ADDR_DRV (ADDR_DRV),
        .ADDR_OWN (ADDR_OWN)
    ) u_fw_rd (
        .clk     (clk),
        .rst     (rst),
        .rd      (fw_rdq),
        .addr    (fw_addr),
        .drv_bit (drv_fw_rbit),
        .reg_bit (reg_fw_rbit),
        .own_img (own_img),
        .rdata   (fw_rdata)
    );

endmodule

// File: rtl/hwsem_chk.sv
module hwsem_chk #(
    parameter int DW      = 32,
    parameter int AW      = 2,
    parameter int NRES    = 5,
    parameter int NFW     = 4,
    parameter int NVM_IDX = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            host_rd,
    input logic            host_wr,
    input logic [AW-1:0]   host_addr,
    input logic [DW-1:0]   host_rdata,
    input logic            fw_rd,
    input logic            fw_wr,
    input logic [AW-1:0]   fw_addr,
    input logic [DW-1:0]   fw_rdata,
    input logic            flash_busy,
    input logic            sem_err,
    input logic            drv_held,
    input logic            reg_held,
    input logic [NRES-1:0] host_own,
    input logic [NFW-1:0]  fw_own
);

    logic host_drv_rd, fw_drv_rd, fw_own_rd;

    assign host_drv_rd = host_rd & ~host_wr & (host_addr == AW'(0));
    assign fw_drv_rd   = fw_rd & ~fw_wr & (fw_addr == AW'(0));
    assign fw_own_rd   = fw_rd & ~fw_wr & (fw_addr == AW'(1));

    // R1: lone host read of a free driver lock returns 0 and takes it
    p_drv_grant_r1: assert property (@(posedge clk) disable iff (rst)
        (host_drv_rd && !fw_drv_rd && !drv_held) |=> (host_rdata == '0 && drv_held));

    // R2: firmware read of a free register lock returns clear bit and takes it
    p_reg_grant_r2: assert property (@(posedge clk) disable iff (rst)
        (fw_own_rd && !reg_held) |=> (fw_rdata[DW-1] == 1'b0 && reg_held));

    // R10: simultaneous reads of a free lock; firmware wins
    p_race_r10: assert property (@(posedge clk) disable iff (rst)
        (host_drv_rd && fw_drv_rd && !drv_held) |=> (fw_rdata[0] == 1'b0 && host_rdata[0] == 1'b1));

    // R5: a resource is never owned by both agents
    p_excl_r5: assert property (@(posedge clk) disable iff (rst)
        ((host_own[NFW-1:0] & fw_own) == '0));

    // R6: host never gains the memory resource while flash is busy
    p_nvm_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(host_own[NVM_IDX]) |-> $past(!flash_busy));

    // R9: error flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        sem_err |=> sem_err);

    // R9: error only rises after an ownership-register write
    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sem_err) |-> $past((host_wr && host_addr == AW'(1)) || (fw_wr && fw_addr == AW'(1))));

endmodule

bind hwsem_unit hwsem_chk #(
    .DW      (DW),
    .AW      (AW),
    .NRES    (NRES),
    .NFW     (NFW),
    .NVM_IDX (NVM_IDX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .fw_rd      (fw_rd),
    .fw_wr      (fw_wr),
    .fw_addr    (fw_addr),
    .fw_rdata   (fw_rdata),
    .flash_busy (flash_busy),
    .sem_err    (sem_err),
    .drv_held   (drv_held),
    .reg_held   (reg_held),
    .host_own   (host_own),
    .fw_own     (fw_own)
);

// File: tb/sim_hwsem_unit.sv
module sim_hwsem_unit;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] L = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        fw_rd = 1'b0, fw_wr = 1'b0;
    logic [1:0]  fw_addr = '0;
    logic [31:0] fw_wdata = '0;
    logic [31:0] fw_rdata;
    logic        flash_busy = 1'b0;
    logic        sem_err;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwsem_unit u0 (
        .clk(clk), .rst(rst),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fw_rd(fw_rd), .fw_wr(fw_wr), .fw_addr(fw_addr),
        .fw_wdata(fw_wdata), .fw_rdata(fw_rdata),
        .flash_busy(flash_busy), .sem_err(sem_err)
    );

    typedef struct packed {
        logic        hr; logic hw; logic [1:0] ha; logic [31:0] hd;
        logic        fr; logic fw; logic [1:0] fa; logic [31:0] fd;
        logic [31:0] eh; logic [31:0] ef; logic ee;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TAB [NV] = '{
        '{1,0,0,0,          0,0,0,0,              32'h0,       32'h0,       0}, // R1 take
        '{1,0,0,0,          0,0,0,0,              32'h1,       32'h0,       0}, // R1 held
        '{0,0,0,0,          1,0,0,0,              32'h0,       32'h1,       0}, // R1 fw sees held
        '{0,1,0,0,          0,0,0,0,              32'h0,       32'h0,       0}, // R3 host free
        '{0,0,0,0,          1,0,0,0,              32'h0,       32'h0,       0}, // R1 fw take
        '{0,0,0,0,          0,1,0,0,              32'h0,       32'h0,       0}, // R3 fw free
        '{1,0,1,0,          0,0,0,0,              32'h0,       32'h0,       0}, // R2 take
        '{0,1,1,L|32'h3,    0,0,0,0,              32'h0,       32'h0,       0}, // R5 claim 0,1
        '{1,0,1,0,          0,0,0,0,              L|32'h3,     32'h0,       0}, // R4
        '{0,1,1,32'h3,      0,0,0,0,              32'h0,       32'h0,       0}, // R3 free reg
        '{0,0,0,0,          1,0,1,0,              32'h0,       32'h3,       0}, // R2 fw take
        '{0,0,0,0,          0,1,1,L|32'hA0,       32'h0,       32'h0,       0}, // R5 res0 denied
        '{0,0,0,0,          1,0,1,0,              32'h0,       L|32'h83,    0}, // R5 R4
        '{1,0,1,0,          0,0,0,0,              L|32'h83,    32'h0,       0}, // R2 host sees held
        '{0,0,0,0,          0,1,1,0,              32'h0,       32'h0,       0}, // R8 fw release
        '{1,0,1,0,          0,0,0,0,              32'h3,       32'h0,       0}, // R8 host kept
        '{0,1,1,L|32'h14,   0,0,0,0,              32'h0,       32'h0,       0}, // R8 R5
        '{0,0,0,0,          0,1,1,L|32'h20,       32'h0,       32'h0,       1}, // R9
        '{1,0,1,0,          0,0,0,0,              L|32'h14,    32'h0,       1}, // R9 ignored
        '{0,1,1,32'h14,     0,0,0,0,              32'h0,       32'h0,       1}, // R3
        '{1,0,1,0,          1,0,1,0,              L|32'h14,    32'h14,      1}, // R10
        '{0,0,0,0,          0,1,1,L|32'h200,      32'h0,       32'h0,       1}, // R7
        '{0,0,0,0,          1,0,1,0,              32'h0,       L|32'h14,    1}, // R7
        '{1,0,0,0,          1,0,0,0,              32'h1,       32'h0,       1}  // R10
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
        fw_rd = 0; fw_wr = 0; fw_addr = 0; fw_wdata = 0;
    endtask

    // Drive at negedge, let one posedge pass, return at the next negedge.
    task automatic host_op(input logic rd, input logic wr, input logic [1:0] a, input logic [31:0] d);
        idle();
        host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic fw_op(input logic rd, input logic wr, input logic [1:0] a, input logic [31:0] d);
        idle();
        fw_rd = rd; fw_wr = wr; fw_addr = a; fw_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        rst = 1;
        idle();
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        @(negedge clk);
        // R11: reset state
        chk("R11 err", {31'b0, sem_err}, 32'h0);
        chk("R11 host_rdata", host_rdata, 32'h0);
        chk("R11 fw_rdata", fw_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            host_rd = TAB[i].hr; host_wr = TAB[i].hw;
            host_addr = TAB[i].ha; host_wdata = TAB[i].hd;
            fw_rd = TAB[i].fr; fw_wr = TAB[i].fw;
            fw_addr = TAB[i].fa; fw_wdata = TAB[i].fd;
            @(negedge clk);
            if (TAB[i].hr && !TAB[i].hw) chk($sformatf("R1/R2/R4 host row %0d", i), host_rdata, TAB[i].eh);
            if (TAB[i].fr && !TAB[i].fw) chk($sformatf("R1/R2/R4 fw row %0d", i), fw_rdata, TAB[i].ef);
            chk($sformatf("R9 err row %0d", i), {31'b0, sem_err}, {31'b0, TAB[i].ee});
        end
        idle();

        // R11: reset mid-run clears error, locks and ownership
        do_reset();
        @(negedge clk);
        chk("R11 err cleared", {31'b0, sem_err}, 32'h0);
        host_op(1, 0, 1, 0);
        chk("R11 ownership cleared", host_rdata, 32'h0);

        // R6: memory resource blocked by flash_busy (host holds reg lock)
        flash_busy = 1;
        host_op(0, 1, 1, L | 32'h8);
        host_op(1, 0, 1, 0);
        chk("R6 denied while flash busy", host_rdata, L | 32'h400);
        flash_busy = 0;
        host_op(0, 1, 1, L | 32'h8);
        host_op(1, 0, 1, 0);
        chk("R6 granted when flash idle", host_rdata, L | 32'h8);

        // R3: non-holder write of 0 does not release the driver lock
        host_op(1, 0, 0, 0);
        chk("R3 host takes drv", host_rdata, 32'h0);
        fw_op(0, 1, 0, 0);
        fw_op(1, 0, 0, 0);
        chk("R3 non-holder release ignored", fw_rdata, 32'h1);
        chk("R3 no error from drv write", {31'b0, sem_err}, 32'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule